// File: doc/BRIEF.md
# Flash Bus Front End

This block sits between the external pins of a small NOR-style flash model and its storage. It decodes chip enable, output enable, write enable and a byte-width select. It serves reads either as 16-bit words or as 8-bit bytes, and it produces a per-bit output-enable vector for the pad ring, so that the data pins are released whenever the part is not being read. Writes are detected on the rising edge of write enable while chip enable is low. A two-write program sequence stores data: a command write arms the block, and the next write carries the data.

A flag input stands for a high-voltage level on address bit 9. While it is set, reads return an identifier code chosen by address bit 0. In byte mode the top data pin is an input that acts as the half-word select, one position below address bit 0. The storage is a reduced model indexed by the low address bits. All pins are sampled on a free-running internal clock. The reset/power-down input clears the control state asynchronously.

Top module: `flash_bus_front`

## Requirements
- R1: With byteN high, a9HiV low and ceN/oeN low, dqOut[15:0] equals the word stored at index addr[MEM_AW-1:0]; higher address bits are ignored, and dqOe is 16'hFFFF.
- R2: With byteN low, dqIn[15] is the byte select: 0 returns bits 7:0 of the addressed word on dqOut[7:0], 1 returns bits 15:8; dqOe is 16'h00FF.
- R3: dqOe is all zero whenever ceN is high or oeN is high, in either bus width.
- R4: While rpN is low, dqOe is all zero whatever the other pins do, and a pulse low on rpN cancels an armed program sequence.
- R5: A write is taken only on a low-to-high transition of weN while ceN is low; a weN rise with ceN high has no effect.
- R6: A write whose dqIn[7:0] equals PROG_CMD (default 8'h40) arms the block; the next write stores its data at its address. A write with any other low byte, when not armed, changes nothing in storage.
- R7: A program in byte mode writes dqIn[7:0] only into the half selected by dqIn[15] (0 = bits 7:0, 1 = bits 15:8); the other half keeps its value.
- R8: With a9HiV high and byteN high, a read returns MFR_ID (default 16'h00A5) when addr[0] is 0 and DEV_ID (default 16'h2C74) when addr[0] is 1, whatever the other address bits.
- R9: With a9HiV high and byteN low, a read returns only the low byte of the selected identifier on dqOut[7:0], and dqIn[15] has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the pins |
| rpN | input | 1 | Reset/power-down, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; write taken on its rise |
| byteN | input | 1 | Low selects byte-wide access |
| a9HiV | input | 1 | High-voltage flag on address bit 9 (identifier reads) |
| addr | input | ADDR_W | Word address |
| dqIn | input | DATA_W | Data bus input side; bit 15 is the byte select in byte mode |
| dqOut | output | DATA_W | Data bus output side |
| dqOe | output | DATA_W | Per-bit output enable for the data pads |

## Verification
The assertions assume that weN rises only while address and data are steady around the sampling edge, and that rpN is low from time zero until the first edges. The stimulus changes pins only on the falling clock edge. It holds address, data and chip enable for two full cycles after each weN rise, and it starts with rpN low for several cycles. Identifier reads and byte-mode traffic keep a9HiV and byteN fixed for the whole of each access.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic wrEn;      // store the current bus data this cycle
    logic byteMode;  // byte-wide access selected
    logic sigMode;   // identifier reads selected
    logic laneSel;   // half-word select in byte mode
    logic driveLo;   // drive the low byte lane
    logic driveHi;   // drive the high byte lane
  } busStrobe_t;

  typedef enum logic {
    CMD_IDLE  = 1'b0,
    CMD_ARMED = 1'b1
  } cmdState_t;

endpackage

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] PROG_CMD = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              byteN,
  input  logic              a9HiV,
  input  logic              laneIn,
  input  logic [BYTE_W-1:0] cmdByte,
  output busStrobe_t        strobe
);

  logic      weQ;
  logic      weRise;
  cmdState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weQ <= 1'b1;
    else       weQ <= weN;
  end

  assign weRise = weN & ~weQ & ~ceN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CMD_IDLE;
    end else if (weRise) begin
      case (state)
        CMD_IDLE:  state <= (cmdByte == PROG_CMD) ? CMD_ARMED : CMD_IDLE;
        CMD_ARMED: state <= CMD_IDLE;
        default:   state <= CMD_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn     = weRise && (state == CMD_ARMED);
    strobe.byteMode = ~byteN;
    strobe.sigMode  = a9HiV;
    strobe.laneSel  = ~byteN & laneIn;
    strobe.driveLo  = rstN & ~ceN & ~oeN;
    strobe.driveHi  = rstN & ~ceN & ~oeN & byteN;
  end

  // R5: a store only follows a weN rise with chip enable low
  a_r5_store_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (!ceN && weN && !$past(weN)));

  // R6: arming only follows a write carrying the program command
  a_r6_arm_by_command: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == CMD_ARMED) |-> ($past(cmdByte) == PROG_CMD && !$past(ceN)));

endmodule

// File: rtl/flash_bus_datapath.sv
module flash_bus_datapath
  import flash_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h2C74
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] wordIdx;
  logic [LANES-1:0]  laneEn;
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] idWord;
  logic              unusedAddrHi;

  assign wordIdx      = addr[MEM_AW-1:0];
  assign unusedAddrHi = ^addr[ADDR_W-1:MEM_AW];

  always_comb begin
    if (strobe.byteMode) laneEn = strobe.laneSel ? 2'b10 : 2'b01;
    else                 laneEn = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneEn[l]) begin
          mem[wordIdx][l*BYTE_W +: BYTE_W] <= strobe.byteMode ?
            dqIn[BYTE_W-1:0] : dqIn[l*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  assign memWord = mem[wordIdx];
  assign idWord  = addr[0] ? DEV_ID : MFR_ID;

  always_comb begin
    if (strobe.sigMode) begin
      dqOut = idWord;
    end else if (strobe.byteMode) begin
      dqOut = {memWord[DATA_W-1:BYTE_W],
               strobe.laneSel ? memWord[DATA_W-1:BYTE_W] : memWord[BYTE_W-1:0]};
    end else begin
      dqOut = memWord;
    end
  end

  // R6: a word program leaves the bus data in the addressed word
  a_r6_word_program_stores: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.byteMode) |=> (mem[$past(wordIdx)] == $past(dqIn)));

  // R7: a low-half byte program keeps the high half
  a_r7_high_half_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.byteMode && !strobe.laneSel) |=>
      (mem[$past(wordIdx)][DATA_W-1:BYTE_W] == $past(memWord[DATA_W-1:BYTE_W])));

  // R8: word-wide identifier reads return one of the two codes
  a_r8_id_word: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sigMode && !strobe.byteMode) |-> (dqOut == MFR_ID || dqOut == DEV_ID));

  // R9: byte-wide identifier reads return a low identifier byte
  a_r9_id_byte: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sigMode && strobe.byteMode) |->
      (dqOut[BYTE_W-1:0] == MFR_ID[BYTE_W-1:0] || dqOut[BYTE_W-1:0] == DEV_ID[BYTE_W-1:0]));

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 8,
  parameter logic [DATA_W/2-1:0] PROG_CMD = 8'h40,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h2C74
) (
  input  logic              clk,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              byteN,
  input  logic              a9HiV,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe
);

  localparam int BYTE_W = DATA_W / 2;

  busStrobe_t strobe;

  flash_bus_ctrl #(
    .BYTE_W   (BYTE_W),
    .PROG_CMD (PROG_CMD)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rpN),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .byteN   (byteN),
    .a9HiV   (a9HiV),
    .laneIn  (dqIn[DATA_W-1]),
    .cmdByte (dqIn[BYTE_W-1:0]),
    .strobe  (strobe)
  );

  flash_bus_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_data (
    .clk    (clk),
    .rstN   (rpN),
    .strobe (strobe),
    .addr   (addr),
    .dqIn   (dqIn),
    .dqOut  (dqOut)
  );

  assign dqOe = {{BYTE_W{strobe.driveHi}}, {BYTE_W{strobe.driveLo}}};

  // R3: pads released when chip or output enable is high
  a_r3_bus_released: assert property (@(posedge clk) disable iff (!rpN)
    (ceN || oeN) |-> (dqOe == '0));

  // R2: upper lane never driven in byte mode
  a_r2_upper_idle_in_byte: assert property (@(posedge clk) disable iff (!rpN)
    !byteN |-> (dqOe[DATA_W-1:BYTE_W] == '0));

endmodule

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;
  localparam int DEPTH      = 1 << MEM_AW;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h2C74;

  logic        clk = 1'b0;
  logic        rpN, ceN, oeN, weN, byteN, a9HiV;
  logic [16:0] addr;
  logic [15:0] dqIn;
  logic [15:0] dqOut;
  logic [15:0] dqOe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_front u_flash_bus_front (
    .clk(clk), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .byteN(byteN), .a9HiV(a9HiV), .addr(addr), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus write; useCe=0 keeps chip enable high during the pulse
  task automatic busWrite(input logic [16:0] a, input logic [15:0] d,
                          input logic lane, input bit useCe);
    @(negedge clk);
    addr = a;
    dqIn = byteN ? d : {lane, 7'h00, d[7:0]};
    oeN  = 1'b1;
    ceN  = !useCe;
    weN  = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic progWord(input logic [16:0] a, input logic [15:0] d);
    busWrite(a, 16'h0040, 1'b0, 1'b1);
    busWrite(a, d, 1'b0, 1'b1);
    model[a[MEM_AW-1:0]] = d;
  endtask

  task automatic progByte(input logic [16:0] a, input logic [7:0] d, input logic lane);
    busWrite(a, 16'h0040, 1'b0, 1'b1);
    busWrite(a, {8'h00, d}, lane, 1'b1);
    model[a[MEM_AW-1:0]][lane*8 +: 8] = d;
  endtask

  // Read access; returns dqOut and dqOe sampled after the pins settle
  task automatic busRead(input logic [16:0] a, input logic lane,
                         output logic [15:0] dOut, output logic [15:0] dEn);
    @(negedge clk);
    addr = a;
    dqIn = {lane, 15'h0};
    ceN  = 1'b0;
    oeN  = 1'b0;
    #1;
    dOut = dqOut;
    dEn  = dqOe;
    @(negedge clk);
    ceN = 1'b1;
    oeN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, en, expw;
    logic [16:0] a;
    rpN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    byteN = 1'b1; a9HiV = 1'b0; addr = '0; dqIn = '0;
    repeat (3) @(negedge clk);
    // R4: reset holds pads released even with a read requested
    ceN = 1'b0; oeN = 1'b0;
    #1 check(dqOe == 16'h0000, "R4 reset releases pads", dqOe, 0);
    byteN = 1'b0;
    #1 check(dqOe == 16'h0000, "R4 reset releases pads byte", dqOe, 0);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1; byteN = 1'b1;
    rpN = 1'b1;
    repeat (2) @(negedge clk);

    // R6: program every word
    for (int i = 0; i < DEPTH; i++) begin
      a = {9'(i * 3), 8'(i)};
      progWord(a, 16'((i * 16'h0123) ^ 16'hA55A));
    end
    // R1: word reads with varied upper address bits
    for (int i = 0; i < DEPTH; i++) begin
      a = {9'(i * 7 + 1), 8'(i)};
      busRead(a, 1'b0, rd, en);
      check(rd == model[i] && en == 16'hFFFF, "R1 word read", {rd, en}, {model[i], 16'hFFFF});
    end
    // R2: byte reads of both halves
    byteN = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int l = 0; l < 2; l++) begin
        busRead(17'(i), 1'(l), rd, en);
        check(rd[7:0] == model[i][l*8 +: 8] && en == 16'h00FF, "R2 byte read",
              {8'h0, rd[7:0], en}, {8'h0, model[i][l*8 +: 8], 16'h00FF});
      end
    end
    // R7: byte programs touch one half only
    for (int i = 0; i < 16; i++) begin
      progByte(17'(i * 5), 8'(8'hC0 ^ i), 1'(i));
    end
    byteN = 1'b1;
    for (int i = 0; i < 16; i++) begin
      busRead(17'(i * 5), 1'b0, rd, en);
      check(rd == model[i * 5], "R7 byte program lane", rd, model[i * 5]);
    end
    // R3: enable combinations in both widths
    for (int m = 0; m < 2; m++) begin
      byteN = 1'(m);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        addr = 17'd9; dqIn = 16'h0;
        ceN = c[0]; oeN = c[1];
        expw = (c != 0) ? 16'h0000 : (m == 1 ? 16'hFFFF : 16'h00FF);
        #1 check(dqOe == expw, "R3 enable decode", dqOe, expw);
      end
      @(negedge clk);
      ceN = 1'b1; oeN = 1'b1;
    end
    // R8: identifier words
    byteN = 1'b1; a9HiV = 1'b1;
    for (int i = 0; i < 8; i++) begin
      a = 17'(i * 16'h2B35);
      busRead(a, 1'b0, rd, en);
      expw = a[0] ? DEV : MFR;
      check(rd == expw && en == 16'hFFFF, "R8 identifier word", rd, expw);
    end
    // R9: identifier low byte, byte select ignored
    byteN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      a = 17'(i * 16'h1C07);
      busRead(a, 1'(i >> 1), rd, en);
      expw = a[0] ? DEV : MFR;
      check(rd[7:0] == expw[7:0] && en == 16'h00FF, "R9 identifier byte",
            rd[7:0], expw[7:0]);
    end
    a9HiV = 1'b0; byteN = 1'b1;
    // R5: command write with chip enable high is not taken
    busWrite(17'd3, 16'h0040, 1'b0, 1'b0);
    busWrite(17'd3, 16'h1234, 1'b0, 1'b1);
    busRead(17'd3, 1'b0, rd, en);
    check(rd == model[3], "R5 write needs chip enable", rd, model[3]);
    // R6: other command values do not arm
    busWrite(17'd4, 16'h0020, 1'b0, 1'b1);
    busWrite(17'd4, 16'h5678, 1'b0, 1'b1);
    busRead(17'd4, 1'b0, rd, en);
    check(rd == model[4], "R6 non-program command", rd, model[4]);
    // R4: reset pulse cancels an armed sequence
    busWrite(17'd5, 16'h0040, 1'b0, 1'b1);
    @(negedge clk); rpN = 1'b0;
    repeat (2) @(negedge clk); rpN = 1'b1;
    busWrite(17'd5, 16'h9ABC, 1'b0, 1'b1);
    busRead(17'd5, 1'b0, rd, en);
    check(rd == model[5], "R4 reset cancels program", rd, model[5]);
    // R6: a fresh sequence still programs afterwards
    progWord(17'd5, 16'h0F1E);
    busRead(17'd5, 1'b0, rd, en);
    check(rd == 16'h0F1E, "R6 program after reset", rd, 16'h0F1E);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule